// File: doc/BRIEF.md
# Symmetric Triangle-Carrier PWM with Per-Event Action Qualifier

This block makes one PWM output from an up-down (triangle) time-base counter. The counter rises from 0 to a programmed period value and then falls back to 0, so the carrier is symmetric and one carrier cycle lasts twice the period value in clocks. Two compare values are tested against the counter on both the rising and the falling slope. Together with counter-at-zero and counter-at-period, this gives six qualified events. A 12-bit action word gives each event a 2-bit code: nothing, force low, force high or toggle.

Software reaches the period, the two compares and the action word through a single write port. Each of the four registers has two copies. Every write lands in the working copy that software sees. A per-register mode input picks one of two behaviours. In the first, the active copy follows at once. In the second, the shadow copy is moved to the active copy on the clock where the counter is at zero. The second mode lets software switch between a one-pulse and a two-pulse pattern between carrier cycles without a broken cycle in the output.

Top module: `sym_pwm_aq`

## Requirements
- R1: After reset the counter moves by exactly one per clock, from 0 up to the active period P and back down to 0. Neither P nor 0 is repeated at a turn, so a carrier cycle is 2·P clocks. `cnt_up` is 1 when the present count was reached while counting up, and 1 at zero after reset.
- R2: A compare event fires for one clock, when the counter equals the compare value. The up variant fires when `cnt_up`=1 and the down variant when `cnt_up`=0. The zero event fires when the counter is 0 and the period event when it equals P.
- R3: Action codes are 00 no change, 01 output low, 10 output high, 11 toggle. `pwm_out` takes the new level on the clock edge that ends the event's cycle.
- R4: Action word fields: [1:0] zero, [3:2] period, [5:4] compare A up, [7:6] compare A down, [9:8] compare B up, [11:10] compare B down.
- R5: When several events with non-zero codes fire on one clock, the order from strongest to weakest is compare B down, compare B up, compare A down, compare A up, period, zero.
- R6: Action word 0x601 with 0<B<P gives one pulse per cycle, high for 2·(P−B) clocks.
- R7: Action word 0x691 with 0<B<A<P gives two pulses per cycle, high for 2·(A−B) clocks in total.
- R8: Word 0x001 with B=P keeps the output low for the whole cycle. Word 0x002 with B=0 keeps it high for the whole cycle.
- R9: With its mode bit at 0, a register write does not affect the active value until the clock where the counter is 0. The new value governs from the next count onwards.
- R10: With its mode bit at 1, a register write reaches the active value on the next clock, in the middle of a cycle.
- R11: Reset (synchronous, active low) gives counter 0, `cnt_up`=1, `pwm_out`=0, and all registers 0.
- R12: Write addresses are 0 period, 1 compare A, 2 compare B, 3 action. `imm_load` bit n is the mode bit of address n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 period, 1 cmp A, 2 cmp B, 3 action) |
| wr_data | input | CNT_W | Write data; action uses bits [11:0] |
| imm_load | input | 4 | Per-register mode: 1 immediate, 0 load at counter zero |
| pwm_out | output | 1 | PWM output |
| cnt_val | output | CNT_W | Present counter value |
| cnt_up | output | 1 | Counter direction of arrival (1 rising) |

## Verification
The bench checks the counter's turns at the period value and at zero. A design that repeated a turn count would stretch each cycle, and the peak and step checks would fail. It measures the high time and pulse count over whole cycles for the one-pulse, two-pulse and constant-level words, and tests coincident compare events, where a wrong priority would raise a pulse that should be suppressed. The sharpest case is an action or period write in the middle of a cycle. In shadow mode, an early transfer would change the running cycle; in immediate mode, a missing bypass would delay the effect by a cycle.

// File: rtl/pwm_aq_pkg.sv
// Package: shared constants and types for the symmetric PWM block.
// Assumes the action word is 12 bits, six 2-bit fields, in event-index order.
package pwm_aq_pkg;
    localparam int ACT_W    = 12;
    localparam int N_EVT    = 6;
    localparam int N_REGS   = 4;

    // Event indices; a higher index wins when several fire together.
    localparam int EV_ZERO  = 0;
    localparam int EV_PRD   = 1;
    localparam int EV_CAU   = 2;
    localparam int EV_CAD   = 3;
    localparam int EV_CBU   = 4;
    localparam int EV_CBD   = 5;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_TOG  = 2'b11
    } act_code_e;

    typedef enum logic [1:0] {
        REG_PRD  = 2'd0,
        REG_CMPA = 2'd1,
        REG_CMPB = 2'd2,
        REG_ACT  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pwm_shadow_reg.sv
// Two-copy register: writes land in the shadow copy. In immediate mode the
// active copy is written on the same edge; otherwise the shadow copy moves
// to the active copy on the clock where the counter is zero.
// Assumes at_zero is high for the whole clock the counter equals 0.
module pwm_shadow_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         imm,
    input  logic         at_zero,
    output logic [W-1:0] active
);
    logic [W-1:0] shadow;

    // Shadow copy: capture every write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= '0;
        else if (wr_en)
            shadow <= wr_data;
    end

    // Active copy: immediate bypass, or transfer at counter zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= '0;
        else if (wr_en && imm)
            active <= wr_data;
        else if (at_zero && !imm)
            active <= shadow;
    end

    // R9
    hold_between_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_zero && !(wr_en && imm)) |=> $stable(active));

    // R10
    imm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && imm) |=> (active == $past(wr_data)));
endmodule

// File: rtl/pwm_timebase.sv
// Up-down time-base counter: 0 -> P -> 0 with no repeated count at either
// turn. up flags the direction by which the present count was reached.
// Assumes the period input is the active period; a period of 0 parks at 0.
module pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] prd,
    output logic [CNT_W-1:0] cnt,
    output logic             up
);
    // Counter and direction update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (up) begin
            if (cnt >= prd) begin
                if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                    up  <= 1'b0;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == '0) begin
                up <= 1'b1;
                if (prd != '0)
                    cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R1
    rise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up && cnt < prd) |=> (up && cnt == $past(cnt) + 1'b1));

    // R1
    fall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R1
    peak_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up && cnt == prd && prd != '0) |=> (!up && cnt == $past(cnt) - 1'b1));

    // R1
    floor_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && cnt == '0 && prd != '0) |=> (up && cnt == 1));
endmodule

// File: rtl/pwm_action_qual.sv
// Action qualifier: decodes the six counter events, picks the strongest
// event that carries a non-zero code, and registers the output level.
// Assumes compares and period are active values from the shadow registers.
module pwm_action_qual
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             up,
    input  logic [CNT_W-1:0] prd,
    input  logic [CNT_W-1:0] cmpa,
    input  logic [CNT_W-1:0] cmpb,
    input  logic [CNT_W-1:0] act,
    output logic             pwm
);
    logic [N_EVT-1:0] evt;
    logic [1:0]       sel_code;
    logic             unused_act;

    assign unused_act = ^act[CNT_W-1:ACT_W];

    // Event decode from counter, direction and thresholds.
    always_comb begin
        evt          = '0;
        evt[EV_ZERO] = (cnt == '0);
        evt[EV_PRD]  = (cnt == prd);
        evt[EV_CAU]  = (cnt == cmpa) &&  up;
        evt[EV_CAD]  = (cnt == cmpa) && !up;
        evt[EV_CBU]  = (cnt == cmpb) &&  up;
        evt[EV_CBD]  = (cnt == cmpb) && !up;
    end

    // Priority pick: later (higher) index overrides when its code is active.
    always_comb begin
        sel_code = ACT_NONE;
        for (int i = 0; i < N_EVT; i++) begin
            if (evt[i] && act[2*i +: 2] != ACT_NONE)
                sel_code = act[2*i +: 2];
        end
    end

    // Output register applying the selected code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm <= 1'b0;
        else begin
            case (sel_code)
                ACT_LOW:  pwm <= 1'b0;
                ACT_HIGH: pwm <= 1'b1;
                ACT_TOG:  pwm <= ~pwm;
                default:  pwm <= pwm;
            endcase
        end
    end

    // R3
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0) |=> $stable(pwm));

    // R5
    cbd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[EV_CBD] && act[11:10] == ACT_HIGH) |=> pwm);

    // R5
    cbd_low_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[EV_CBD] && act[11:10] == ACT_LOW) |=> !pwm);
endmodule

// File: rtl/sym_pwm_aq.sv
// Top: symmetric triangle-carrier PWM with per-event action qualifier and
// shadowed period, compare A, compare B and action registers.
// Assumes CNT_W >= 12 so the action word fits the write data.
module sym_pwm_aq
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [3:0]       imm_load,
    output logic             pwm_out,
    output logic [CNT_W-1:0] cnt_val,
    output logic             cnt_up
);
    logic [CNT_W-1:0] act_val [N_REGS];
    logic             at_zero;

    assign at_zero = (cnt_val == '0);

    // One two-copy register per write address (R12 decode).
    for (genvar g = 0; g < N_REGS; g++) begin : g_regs
        pwm_shadow_reg #(.W(CNT_W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_addr == 2'(g))),
            .wr_data (wr_data),
            .imm     (imm_load[g]),
            .at_zero (at_zero),
            .active  (act_val[g])
        );
    end

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .prd   (act_val[REG_PRD]),
        .cnt   (cnt_val),
        .up    (cnt_up)
    );

    pwm_action_qual #(.CNT_W(CNT_W)) u_aq (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt_val),
        .up    (cnt_up),
        .prd   (act_val[REG_PRD]),
        .cmpa  (act_val[REG_CMPA]),
        .cmpb  (act_val[REG_CMPB]),
        .act   (act_val[REG_ACT]),
        .pwm   (pwm_out)
    );
endmodule

// File: tb/sym_pwm_aq_test.sv
module sym_pwm_aq_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [3:0]   imm_load = 4'hF;
    logic         pwm_out;
    logic [W-1:0] cnt_val;
    logic         cnt_up;

    int checks = 0;
    int errors = 0;
    int hi_cnt, rises, peak, bad_steps;
    logic prev_out;

    sym_pwm_aq #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .imm_load(imm_load), .pwm_out(pwm_out),
        .cnt_val(cnt_val), .cnt_up(cnt_up)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d, input logic [3:0] m);
        @(negedge clk);
        prev_out = pwm_out;
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d); imm_load = m;
        @(negedge clk);
        prev_out = pwm_out;
        wr_en = 1'b0;
    endtask

    task automatic wait_at(input int v, input logic dir);
        int guard = 0;
        do begin
            @(negedge clk);
            prev_out = pwm_out;
            guard++;
        end while (!(cnt_val == W'(v) && cnt_up == dir) && guard < 500);
    endtask

    // Load all registers immediately, then run one whole cycle to settle.
    task automatic setup(input int p, input int a, input int b, input int act);
        wr(2'd0, p, 4'hF);
        wr(2'd1, a, 4'hF);
        wr(2'd2, b, 4'hF);
        wr(2'd3, act, 4'hF);
        imm_load = 4'h0;
        wait_at(1, 1'b1);
        wait_at(1, 1'b1);
    endtask

    // Observe one whole cycle starting at count 1 rising (2*p samples).
    task automatic measure(input int p);
        int last;
        wait_at(1, 1'b1);
        hi_cnt = 0; rises = 0; peak = 0; bad_steps = 0;
        last = 0;
        for (int i = 0; i < 2 * p; i++) begin
            if (i > 0) @(negedge clk);
            if (pwm_out) hi_cnt++;
            if (pwm_out && !prev_out) rises++;
            if (int'(cnt_val) > peak) peak = int'(cnt_val);
            if (i > 0 && int'(cnt_val) != last + 1 && int'(cnt_val) != last - 1)
                bad_steps++;
            last = int'(cnt_val);
            prev_out = pwm_out;
        end
    endtask

    task automatic t_reset;
        check("R11 counter", int'(cnt_val), 0);
        check("R11 cnt_up", int'(cnt_up), 1);
        check("R11 pwm_out", int'(pwm_out), 0);
    endtask

    task automatic t_one_pulse;
        setup(20, 12, 5, 'h601);
        measure(20);
        check("R1 peak", peak, 20);
        check("R1 steps", bad_steps, 0);
        check("R6 high time", hi_cnt, 30);
        check("R6 pulses", rises, 1);
    endtask

    task automatic t_two_pulse;
        setup(20, 12, 5, 'h691);
        measure(20);
        check("R7 high time", hi_cnt, 14);
        check("R7 pulses", rises, 2);
        check("R4 R2 pulses", rises, 2);
    endtask

    task automatic t_constant;
        setup(20, 12, 20, 'h001);
        measure(20);
        check("R8 low word", hi_cnt, 0);
        setup(20, 12, 0, 'h002);
        measure(20);
        check("R8 high word", hi_cnt, 40);
    endtask

    task automatic t_priority;
        setup(20, 8, 8, 'h001);
        wr(2'd3, 'h120, 4'h8);
        imm_load = 4'h0;
        measure(20);
        check("R5 cbu over cau", hi_cnt, 0);
    endtask

    task automatic t_toggle;
        int first;
        setup(20, 12, 5, 'h300);
        wait_at(10, 1'b1);
        first = int'(pwm_out);
        wait_at(10, 1'b1);
        check("R3 toggle", int'(pwm_out), 1 - first);
    endtask

    task automatic t_shadow_action;
        setup(20, 12, 5, 'h601);
        wait_at(8, 1'b1);
        wr(2'd3, 'h691, 4'h0);
        wait_at(14, 1'b1);
        check("R9 held word", int'(pwm_out), 1);
        measure(20);
        check("R9 next cycle high", hi_cnt, 14);
        check("R9 R12 next cycle pulses", rises, 2);
    endtask

    task automatic t_imm_action;
        setup(20, 12, 5, 'h601);
        wait_at(8, 1'b1);
        wr(2'd3, 'h001, 4'h8);
        imm_load = 4'h0;
        wait_at(3, 1'b0);
        check("R10 immediate word", int'(pwm_out), 1);
    endtask

    task automatic t_shadow_period;
        setup(20, 12, 5, 'h601);
        wait_at(5, 1'b1);
        wr(2'd0, 30, 4'h0);
        wait_at(20, 1'b1);
        @(negedge clk);
        prev_out = pwm_out;
        check("R9 old period turn", int'(cnt_val), 19);
        measure(30);
        check("R9 new period peak", peak, 30);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_one_pulse();
        t_two_pulse();
        t_constant();
        t_priority();
        t_toggle();
        t_shadow_action();
        t_imm_action();
        t_shadow_period();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule